// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block produces the system's active-low reset from two sources: a digital supply-good flag and a watchdog timer. Reset stays asserted from power-up and for as long as the supply flag is low. It is released only after the flag has stayed high for a fixed number of timebase ticks. Any low sample during that countdown starts the countdown again.

Once the system runs, the watchdog expects regular activity on a two-wire serial bus. Each START condition (SDA falling while SCL is high) restarts it. SCL and SDA pass through two-flop synchronizers before START detection. A two-bit select picks one of three timeouts, and the fourth code turns the watchdog off. The select is sampled only when the watchdog restarts.

When the watchdog expires, the block emits a one-cycle bite pulse and holds reset for a fixed number of ticks. The watchdog then restarts from zero. A bus-inhibit output tells the serial slave logic to abort any transaction in progress and refuse new ones for as long as reset is active. A nonvolatile write that has already started is left for the slave to finish. All durations are counted in timebase ticks and set by parameters.

Top module: `sup_reset_ctrl`

## Requirements
- R1: `sys_rst_n` is 0 while `rst_n` is low. On any clock edge where `supply_ok` is sampled 0, `sys_rst_n` is 0 from the next cycle on.
- R2: After `supply_ok` goes high, `sys_rst_n` rises once POR_TICKS ticks (default 20) have been counted with the flag continuously high.
- R3: A single low sample of `supply_ok` during the release countdown restarts the countdown from zero.
- R4: A START condition restarts the watchdog count. A START is the synchronized SDA going 1 to 0 while the synchronized SCL is 1 on both samples. An SDA fall while SCL is 0 has no effect.
- R5: The watchdog select code `wd_sel` gives these timeouts: 2'b00 = LIM_LONG ticks (140), 2'b01 = LIM_MID (60), 2'b10 = LIM_SHORT (20). Code 2'b11 disables the watchdog, so it never expires.
- R6: On expiry, `wd_bite` is high for exactly one cycle and reset is held for HOLD_TICKS ticks (25). A START during this hold does not shorten it. The watchdog then restarts from zero.
- R7: The watchdog does not count while reset is asserted by the supply path. It starts from zero when reset is released, so the first expiry comes a full timeout after release.
- R8: `bus_inhibit` is 1 exactly when `sys_rst_n` is 0.
- R9: `wd_sel` is latched only when the watchdog restarts (reset release, START, or end of hold). A change made mid-count does not alter the running timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Supply above threshold, synchronous to clk |
| tick | input | 1 | One-cycle timebase pulse |
| scl_in | input | 1 | Raw serial clock level |
| sda_in | input | 1 | Raw serial data level |
| wd_sel | input | 2 | Watchdog timeout select |
| sys_rst_n | output | 1 | System reset, active low |
| bus_inhibit | output | 1 | Tells the serial slave to abort and refuse transactions |
| wd_bite | output | 1 | One-cycle pulse when the watchdog expires |

## Verification
The properties take for granted that `supply_ok` is already synchronous to `clk`. They also assume `rst_n` is released only once and that the supply path can reset the watchdog at any moment. The stimulus respects this:
- `supply_ok`, `wd_sel` and the bus levels change only between clock edges and are held for whole cycles.
- SCL and SDA transitions are spaced several cycles apart so the synchronizers see every level.
- `tick` comes from a free-running divider.

Because the tick phase relative to each stimulus is unknown, each expected reset edge or bite is given a window of about two tick periods.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_code_e;

  typedef enum logic {
    WD_RUN  = 1'b0,
    WD_HOLD = 1'b1
  } wd_state_e;
endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter int W = 2,
  parameter logic IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= IDLE;
        q[i] <= IDLE;
      end else begin
        meta <= d[i];
        q[i] <= meta;
      end
    end
  end
endmodule

// File: rtl/sup_start_det.sv
module sup_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  // SDA falling while SCL held high on both samples
  assign start = scl_s & scl_d & sda_d & ~sda_s;
endmodule

// File: rtl/sup_por_timer.sv
module sup_por_timer #(
  parameter int POR_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic tick,
  output logic por_done
);
  localparam int PW = $clog2(POR_TICKS + 1);
  localparam logic [PW-1:0] LAST = PW'(POR_TICKS - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      por_done <= 1'b0;
    end else if (!supply_ok) begin
      cnt      <= '0;
      por_done <= 1'b0;
    end else if (!por_done && tick) begin
      if (cnt == LAST) por_done <= 1'b1;
      else             cnt      <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int LIM_LONG   = 140,
  parameter int LIM_MID    = 60,
  parameter int LIM_SHORT  = 20,
  parameter int HOLD_TICKS = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       tick,
  input  logic       kick,
  input  logic [1:0] sel,
  output logic       hold,
  output logic       bite
);
  localparam int M1   = (LIM_LONG > LIM_MID) ? LIM_LONG : LIM_MID;
  localparam int M2   = (M1 > LIM_SHORT) ? M1 : LIM_SHORT;
  localparam int MAXL = (M2 > HOLD_TICKS) ? M2 : HOLD_TICKS;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_TICKS - 1);

  wd_state_e     st;
  logic [CW-1:0] cnt;
  logic [1:0]    sel_q;
  logic [CW-1:0] lim_last;
  logic          enabled, expire, hold_end;

  function automatic logic [CW-1:0] last_of(input logic [1:0] c);
    case (c)
      WD_LONG:  return CW'(LIM_LONG - 1);
      WD_MID:   return CW'(LIM_MID - 1);
      WD_SHORT: return CW'(LIM_SHORT - 1);
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    lim_last = last_of(sel_q);
    enabled  = (sel_q != WD_OFF);
    expire   = run_en && (st == WD_RUN) && enabled && tick && !kick &&
               (cnt == lim_last);
    hold_end = (st == WD_HOLD) && tick && (cnt == HOLD_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= WD_RUN;
      cnt   <= '0;
      sel_q <= WD_OFF;
      bite  <= 1'b0;
    end else begin
      bite <= expire;
      if (!run_en) begin
        st    <= WD_RUN;
        cnt   <= '0;
        sel_q <= sel;
      end else if (st == WD_HOLD) begin
        if (hold_end) begin
          st    <= WD_RUN;
          cnt   <= '0;
          sel_q <= sel;
        end else if (tick) begin
          cnt <= cnt + 1'b1;
        end
      end else if (kick) begin
        cnt   <= '0;
        sel_q <= sel;
      end else if (expire) begin
        st  <= WD_HOLD;
        cnt <= '0;
      end else if (tick && enabled) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign hold = (st == WD_HOLD);
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int POR_TICKS  = 20,
  parameter int HOLD_TICKS = 25,
  parameter int LIM_LONG   = 140,
  parameter int LIM_MID    = 60,
  parameter int LIM_SHORT  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       tick,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] wd_sel,
  output logic       sys_rst_n,
  output logic       bus_inhibit,
  output logic       wd_bite
);
  logic [1:0] bus_s;
  logic       start, por_done, wd_hold;

  sup_sync2 #(.W(2), .IDLE(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_in, sda_in}),
    .q    (bus_s)
  );

  sup_start_det u_start (
    .clk  (clk),
    .rst_n(rst_n),
    .scl_s(bus_s[1]),
    .sda_s(bus_s[0]),
    .start(start)
  );

  sup_por_timer #(.POR_TICKS(POR_TICKS)) u_por (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .tick     (tick),
    .por_done (por_done)
  );

  sup_wdog #(
    .LIM_LONG  (LIM_LONG),
    .LIM_MID   (LIM_MID),
    .LIM_SHORT (LIM_SHORT),
    .HOLD_TICKS(HOLD_TICKS)
  ) u_wd (
    .clk   (clk),
    .rst_n (rst_n),
    .run_en(por_done),
    .tick  (tick),
    .kick  (start),
    .sel   (wd_sel),
    .hold  (wd_hold),
    .bite  (wd_bite)
  );

  assign sys_rst_n   = por_done & ~wd_hold;
  assign bus_inhibit = ~sys_rst_n;
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic sys_rst_n,
  input logic bus_inhibit,
  input logic wd_bite
);
  p_low_supply_resets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !sys_rst_n);

  p_release_needs_supply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(supply_ok));

  p_inhibit_tracks_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_inhibit == !sys_rst_n);

  p_bite_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_bite |=> !wd_bite);

  p_bite_enters_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_bite |-> !sys_rst_n);

  p_bite_only_from_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_bite |-> $past(sys_rst_n));
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_ok  (supply_ok),
  .sys_rst_n  (sys_rst_n),
  .bus_inhibit(bus_inhibit),
  .wd_bite    (wd_bite)
);

// File: tb/sup_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module sup_reset_ctrl_tb_top;
  localparam int TP   = 4;
  localparam int POR  = 20;
  localparam int HOLD = 25;
  localparam int LL   = 140;
  localparam int LM   = 60;
  localparam int LS   = 20;
  localparam int TOL  = 2*TP + 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0;
  logic       tick = 1'b0;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic [1:0] wd_sel = 2'b11;
  logic       sys_rst_n, bus_inhibit, wd_bite;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int    kind;   // 0 reset fall, 1 reset rise, 2 bite
    int    at;
    string req;
  } exp_t;
  exp_t q[$];

  sup_reset_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .tick       (tick),
    .scl_in     (scl),
    .sda_in     (sda),
    .wd_sel     (wd_sel),
    .sys_rst_n  (sys_rst_n),
    .bus_inhibit(bus_inhibit),
    .wd_bite    (wd_bite)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tick <= ((cyc % TP) == 0);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int k, input int at, input string req);
    exp_t e;
    e.kind = k; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic match(input int k);
    exp_t e;
    int d;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL R5 R6 unexpected event kind actual=%0d expected=none at cycle %0d", k, cyc);
    end else begin
      e = q.pop_front();
      d = cyc - e.at;
      if (d < 0) d = -d;
      if (e.kind != k || d > TOL) begin
        errors++;
        $display("FAIL %s event kind/cycle actual=%0d/%0d expected=%0d/%0d",
                 e.req, k, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor: pops the scoreboard as output edges appear
  logic prev_rst = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rst && !sys_rst_n) match(0);
      if (wd_bite) match(2);
      if (!prev_rst && sys_rst_n) match(1);
      if (bus_inhibit == sys_rst_n) begin
        checks++;
        errors++;
        $display("FAIL R8 bus_inhibit actual=%0d expected=%0d", bus_inhibit, !sys_rst_n);
      end
    end
    prev_rst <= sys_rst_n;
  end

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_start(output int at);
    scl = 1'b1; sda = 1'b1;
    repeat (3) @(negedge clk);
    sda = 1'b0; at = cyc;
    repeat (3) @(negedge clk);
    scl = 1'b0;
    repeat (2) @(negedge clk);
    sda = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sda_wiggle_scl_low();
    scl = 1'b0;
    repeat (2) @(negedge clk);
    sda = 1'b0;
    repeat (3) @(negedge clk);
    sda = 1'b1;
    repeat (3) @(negedge clk);
    scl = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc == 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t, t2, t3, tl, td, tu, dummy;
    repeat (5) @(negedge clk);
    chk(sys_rst_n == 1'b0, "R1", "reset level in power-on", sys_rst_n, 0);
    chk(bus_inhibit == 1'b1, "R8", "inhibit in power-on", bus_inhibit, 1);
    chk(wd_bite == 1'b0, "R6", "no bite in power-on", wd_bite, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(sys_rst_n == 1'b0, "R1", "held while supply low", sys_rst_n, 0);

    // R2 / R3: countdown with one-cycle glitch
    supply_ok = 1'b1;
    repeat (8*TP) @(negedge clk);
    chk(sys_rst_n == 1'b0, "R2", "still counting", sys_rst_n, 0);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1; t = cyc;
    push(1, t + POR*TP, "R2 R3");
    repeat (POR*TP - 14) @(negedge clk);
    chk(sys_rst_n == 1'b0, "R3", "countdown restarted after glitch", sys_rst_n, 0);
    wait_until(t + POR*TP + 20);
    chk(sys_rst_n == 1'b1, "R2", "released after countdown", sys_rst_n, 1);

    // R5: code 11 never expires
    repeat (200*TP) @(negedge clk);
    chk(sys_rst_n == 1'b1, "R5", "disabled watchdog quiet", sys_rst_n, 1);
    chk(q.size() == 0, "R5", "scoreboard drained", q.size(), 0);

    // R5 / R9 / R6: mid then short then long timeouts
    wd_sel = 2'b01;
    do_start(t);
    push(0, t + LM*TP, "R5 R9");
    push(2, t + LM*TP, "R6");
    push(1, t + LM*TP + HOLD*TP, "R6");
    t2 = t + LM*TP + HOLD*TP;
    push(0, t2 + LS*TP, "R9");
    push(2, t2 + LS*TP, "R6");
    push(1, t2 + LS*TP + HOLD*TP, "R6");
    t3 = t2 + LS*TP + HOLD*TP;
    push(0, t3 + LL*TP, "R5");
    push(2, t3 + LL*TP, "R6");
    push(1, t3 + LL*TP + HOLD*TP, "R6");
    wait_until(t + 100);
    wd_sel = 2'b10;             // R9: must not shorten the running period
    wait_until(t + LM*TP + 30);
    chk(sys_rst_n == 1'b0, "R6", "held during watchdog reset", sys_rst_n, 0);
    do_start(dummy);            // R6: START inside hold is ignored
    wait_until(t2 + LS*TP + 40);
    wd_sel = 2'b00;
    wait_until(t3 + LL*TP + 40);
    wd_sel = 2'b11;
    wait_until(t3 + LL*TP + HOLD*TP + 200);
    chk(sys_rst_n == 1'b1, "R5", "off after final restart", sys_rst_n, 1);
    chk(q.size() == 0, "R6", "all watchdog events seen", q.size(), 0);

    // R4: repeated STARTs keep it alive; SDA edges with SCL low do not
    wd_sel = 2'b10;
    do_start(t);
    for (int k = 0; k < 5; k++) begin
      wait_until(t + 15*TP);
      do_start(t);
    end
    tl = t;
    push(0, tl + LS*TP, "R4");
    push(2, tl + LS*TP, "R4");
    push(1, tl + LS*TP + HOLD*TP, "R6");
    wait_until(tl + 20);
    sda_wiggle_scl_low();
    wait_until(tl + LS*TP + 40);
    wd_sel = 2'b11;
    wait_until(tl + LS*TP + HOLD*TP + 100);
    chk(sys_rst_n == 1'b1, "R4", "running after kick test", sys_rst_n, 1);

    // R1 / R7: supply drop while watchdog runs
    wd_sel = 2'b10;
    do_start(t);
    wait_until(t + 20);
    supply_ok = 1'b0; td = cyc;
    push(0, td + 1, "R1");
    repeat (10) @(negedge clk);
    do_start(dummy);
    chk(sys_rst_n == 1'b0, "R1", "reset while supply low", sys_rst_n, 0);
    chk(bus_inhibit == 1'b1, "R8", "inhibit while supply low", bus_inhibit, 1);
    wait_until(td + 200);
    supply_ok = 1'b1; tu = cyc;
    push(1, tu + POR*TP, "R2");
    push(0, tu + POR*TP + LS*TP, "R7");
    push(2, tu + POR*TP + LS*TP, "R7");
    push(1, tu + POR*TP + LS*TP + HOLD*TP, "R6");
    wait_until(tu + POR*TP + LS*TP + 30);
    wd_sel = 2'b11;
    wait_until(tu + POR*TP + LS*TP + HOLD*TP + 100);
    chk(sys_rst_n == 1'b1, "R7", "released at end", sys_rst_n, 1);
    chk(bus_inhibit == 1'b0, "R8", "inhibit clear at end", bus_inhibit, 0);
    chk(q.size() == 0, "R7", "scoreboard drained at end", q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule